// File: doc/BRIEF.md
# Platform Identification Register Port

This block is a 16-byte register window on a simple I/O bus. Each access is 1, 2 or 4 bytes wide, and the value that comes back depends on both the offset and the access size. A 16-bit read at the base offset returns an identification signature. Software probes for that signature before it loads its drivers. A separate blacklist input swaps the two bytes of the signature. Drivers that see the swapped value refuse to run.

The window also does the following:
- It holds a platform-flags byte. The only live bit in that byte is a ROM lock, which drives a level output to the memory-protection logic.
- It latches a 16-bit driver product version.
- It forwards single characters from the guest to a log sink.
- It turns a 16-bit unplug mask into one-cycle request pulses, one output per device class. The logic that actually removes the devices is outside this block.

The log output is a valid/ready stream with a single slot. A byte offered on it stays unchanged until the sink takes it with `log_ready`. The bus side has no wait states. A new log byte that arrives while the slot is full and the sink is not ready this cycle is discarded. A slot that drains in the same cycle as a new byte arrives accepts the new byte.

Top module: `plat_id_port`

## Requirements
- R1: A 16-bit read (`bus_size`=2) at offset 0 returns 0x0000_49D2, or 0x0000_D249 while `blacklist` is high. Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.
- R2: A 16-bit read at any offset other than 0 returns 0x0000_FFFF.
- R3: An 8-bit read (`bus_size`=1) returns the following:
  - at offset 0, the flags byte, zero-extended;
  - at offset 2, the version value 0x01;
  - at any other offset, 0x0000_00FF.
- R4: An 8-bit write to offset 0 keeps only `bus_wdata` bit 0 as the ROM-lock flag. The other flag bits read back as 0. `rom_lock` follows the flag from the next cycle.
- R5: Reset, and the first cycle after reset, act as an 8-bit write of 0 to offset 0. Flags read 0 and `rom_lock` is low. In that first cycle this internal write takes priority over a bus write to the flags.
- R6: A 16-bit write to offset 0 is an unplug mask. Bits 15:3 are ignored. The three low bits map to the bits of `unplug_req` as follows, and each set bit raises its bit for exactly the cycle after the write:

  | Mask bit | `unplug_req` bit | Device class |
  |---|---|---|
  | 0 | 0 | all disks |
  | 1 | 1 | all network adapters |
  | 2 | 2 | auxiliary disks |

- R7: A mask with bit 2 set also sets `unsup_seen`. Only reset clears it.
- R8: A 16-bit write to offset 2 latches `bus_wdata[15:0]` onto `drv_version` from the next cycle.
- R9: An 8-bit write to offset 2 loads `bus_wdata[7:0]` into the log slot. `log_valid` and `log_data` hold until `log_ready`. A write made while the slot is full and `log_ready` is low is dropped.
- R10: A 32-bit access (`bus_size`=4) behaves as follows:
  - a write changes nothing;
  - a read, or a read with any size code other than 1, 2 or 4, returns 0xFFFF_FFFF.
- R11: Writes at offsets other than 0 and 2 change no flag, version, log slot or request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| blacklist | input | 1 | Selects the byte-swapped signature |
| unplug_req | output | 3 | One-cycle unplug request pulses |
| unsup_seen | output | 1 | Sticky: an auxiliary-disk unplug was requested |
| rom_lock | output | 1 | ROM area read-only select |
| drv_version | output | 16 | Latched driver product version |
| log_data | output | 8 | Log byte |
| log_valid | output | 1 | Log byte present |
| log_ready | input | 1 | Log sink accepts the byte |

## Verification
The unplug function is driven with several masks:
- a single bit at a time, which separates the three class outputs from each other;
- all ones with upper garbage bits, which shows that bits 15:3 are ignored;
- zero, which must produce no pulse.

Each pulse is checked in the cycle after the write and again one cycle later, so a stuck or lengthened pulse is caught.

The signature read is repeated with `blacklist` high and low to catch a missing byte swap. The same offsets are read at every size, which exposes size-decode mix-ups.

The log stream is filled while the sink stalls, to show that the held byte survives a second write. The sink is then released to show that the slot drains.

// File: rtl/plat_id_pkg.sv
package plat_id_pkg;
  localparam logic [2:0] SZ_BYTE = 3'd1;
  localparam logic [2:0] SZ_HALF = 3'd2;
  localparam logic [2:0] SZ_WORD = 3'd4;

  localparam logic [3:0] OFS_CTRL = 4'd0;
  localparam logic [3:0] OFS_AUX  = 4'd2;

  // Decoded write strobes from one bus cycle.
  typedef struct packed {
    logic flags_wr;
    logic log_wr;
    logic unplug_wr;
    logic ver_wr;
  } wr_strb_t;
endpackage

// File: rtl/plat_id_decode.sv
module plat_id_decode
  import plat_id_pkg::*;
(
  input  logic [3:0] addr,
  input  logic [2:0] size,
  input  logic       wr,
  output wr_strb_t   strb
);
  logic is_b, is_h, at_ctrl, at_aux;

  always_comb begin
    is_b    = (size == SZ_BYTE);
    is_h    = (size == SZ_HALF);
    at_ctrl = (addr == OFS_CTRL);
    at_aux  = (addr == OFS_AUX);
    strb.flags_wr  = wr && is_b && at_ctrl;
    strb.log_wr    = wr && is_b && at_aux;
    strb.unplug_wr = wr && is_h && at_ctrl;
    strb.ver_wr    = wr && is_h && at_aux;
  end
endmodule

// File: rtl/plat_id_regs.sv
module plat_id_regs
  import plat_id_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VER_W  = 16,
  parameter int LOG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_strb_t          strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [7:0]        flags,
  output logic [VER_W-1:0]  version,
  output logic [LOG_W-1:0]  log_data,
  output logic              log_valid,
  input  logic              log_ready
);
  // Reset re-enters through the normal flags-write path with data 0.
  logic       init_q;
  logic       flags_we;
  logic [7:0] flags_d;
  logic       slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= 1'b1;
    else        init_q <= 1'b0;
  end

  always_comb begin
    flags_we = strb.flags_wr | init_q;
    flags_d  = init_q ? 8'h00 : {7'b0, wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_we) flags <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           version <= '0;
    else if (strb.ver_wr) version <= wdata[VER_W-1:0];
  end

  assign slot_free = !log_valid || log_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_valid <= 1'b0;
      log_data  <= '0;
    end else if (strb.log_wr && slot_free) begin
      log_valid <= 1'b1;
      log_data  <= wdata[LOG_W-1:0];
    end else if (log_ready) begin
      log_valid <= 1'b0;
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(strb.flags_wr) && !$past(init_q)) |-> $stable(flags)); // R4
  AST_FLAGS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flags[7:1] == 7'd0); // R4
  AST_LOG_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_ready) |=> (log_valid && $stable(log_data))); // R9
  AST_VER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strb.ver_wr) |-> $stable(version)); // R8
endmodule

// File: rtl/plat_id_unplug.sv
module plat_id_unplug #(
  parameter int NUM_CLS = 3,
  parameter int AUX_IDX = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unplug_wr,
  input  logic [NUM_CLS-1:0] mask,
  output logic [NUM_CLS-1:0] pulse,
  output logic               unsup
);
  for (genvar i = 0; i < NUM_CLS; i++) begin : g_cls
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else        pulse[i] <= unplug_wr && mask[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           unsup <= 1'b0;
    else if (unplug_wr && mask[AUX_IDX])  unsup <= 1'b1;
  end

  AST_UNSUP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(unsup) |-> unsup); // R7
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse != '0) |-> $past(unplug_wr)); // R6
endmodule

// File: rtl/plat_id_port.sv
module plat_id_port
  import plat_id_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          VER_W    = 16,
  parameter int          LOG_W    = 8,
  parameter int          NUM_CLS  = 3,
  parameter int          AUX_IDX  = 2,
  parameter logic [15:0] SIG      = 16'h49D2,
  parameter logic [7:0]  VER_BYTE = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         bus_addr,
  input  logic [2:0]         bus_size,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               blacklist,
  output logic [NUM_CLS-1:0] unplug_req,
  output logic               unsup_seen,
  output logic               rom_lock,
  output logic [VER_W-1:0]   drv_version,
  output logic [LOG_W-1:0]   log_data,
  output logic               log_valid,
  input  logic               log_ready
);
  localparam logic [15:0] SIG_SWAP = {SIG[7:0], SIG[15:8]};

  wr_strb_t          strb;
  logic [7:0]        flags;
  logic [DATA_W-1:0] rd_val;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  plat_id_decode u_dec (
    .addr (bus_addr),
    .size (bus_size),
    .wr   (bus_wr),
    .strb (strb)
  );

  plat_id_regs #(.DATA_W(DATA_W), .VER_W(VER_W), .LOG_W(LOG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .wdata     (bus_wdata),
    .flags     (flags),
    .version   (drv_version),
    .log_data  (log_data),
    .log_valid (log_valid),
    .log_ready (log_ready)
  );

  plat_id_unplug #(.NUM_CLS(NUM_CLS), .AUX_IDX(AUX_IDX)) u_unplug (
    .clk       (clk),
    .rst_n     (rst_n),
    .unplug_wr (strb.unplug_wr),
    .mask      (bus_wdata[NUM_CLS-1:0]),
    .pulse     (unplug_req),
    .unsup     (unsup_seen)
  );

  assign rom_lock = flags[0];

  always_comb begin
    rd_val = '1;
    if (bus_size == SZ_BYTE) begin
      rd_val = DATA_W'(8'hFF);
      if (bus_addr == OFS_CTRL)     rd_val = DATA_W'(flags);
      else if (bus_addr == OFS_AUX) rd_val = DATA_W'(VER_BYTE);
    end else if (bus_size == SZ_HALF) begin
      rd_val = DATA_W'(16'hFFFF);
      if (bus_addr == OFS_CTRL) rd_val = DATA_W'(blacklist ? SIG_SWAP : SIG);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  AST_SIG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_size == SZ_HALF && bus_addr == OFS_CTRL && !blacklist)
      |-> bus_rdata == DATA_W'(SIG)); // R1
  AST_WORD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_size == SZ_WORD) |-> bus_rdata == '1); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R1
  AST_NIC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    unplug_req[1] |-> $past(bus_wr && bus_size == SZ_HALF && bus_addr == OFS_CTRL
                            && bus_wdata[1])); // R6
  AST_LOCK_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_lock) |-> $past(bus_wr && bus_size == SZ_BYTE && bus_addr == OFS_CTRL)); // R4
endmodule

// File: tb/test_plat_id_port.sv
`timescale 1ns/1ps
module test_plat_id_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [2:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        blacklist = 1'b0;
  logic [2:0]  unplug_req;
  logic        unsup_seen;
  logic        rom_lock;
  logic [15:0] drv_version;
  logic [7:0]  log_data;
  logic        log_valid;
  logic        log_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  plat_id_port i_plat_id_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .blacklist(blacklist), .unplug_req(unplug_req),
    .unsup_seen(unsup_seen), .rom_lock(rom_lock), .drv_version(drv_version),
    .log_data(log_data), .log_valid(log_valid), .log_ready(log_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs change on the falling edge; results are sampled on the next falling edge.
  task automatic bus_write(input logic [3:0] a, input logic [2:0] s, input logic [31:0] d);
    bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [2:0] s, output logic [31:0] d);
    bus_addr = a; bus_size = s; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R5 rom_lock after reset", {31'b0, rom_lock}, 32'h0);
    chk("R7 unsup_seen after reset", {31'b0, unsup_seen}, 32'h0);
    chk("R6 no pulses after reset", {29'b0, unplug_req}, 32'h0);
    bus_read(4'd0, 3'd1, v);
    chk("R5 flags after reset", v, 32'h0);
  endtask

  task automatic t_signature;
    logic [31:0] v;
    bus_read(4'd0, 3'd2, v);
    chk("R1 signature", v, 32'h0000_49D2);
    blacklist = 1'b1;
    bus_read(4'd0, 3'd2, v);
    chk("R1 blacklisted signature", v, 32'h0000_D249);
    blacklist = 1'b0;
    @(negedge clk);
    chk("R1 rdata holds without read", bus_rdata, 32'h0000_D249);
    bus_read(4'd2, 3'd2, v);
    chk("R2 halfword other offset", v, 32'h0000_FFFF);
    bus_read(4'd14, 3'd2, v);
    chk("R2 halfword offset 14", v, 32'h0000_FFFF);
  endtask

  task automatic t_byte_reads;
    logic [31:0] v;
    bus_read(4'd2, 3'd1, v);
    chk("R3 version byte", v, 32'h0000_0001);
    bus_read(4'd1, 3'd1, v);
    chk("R3 byte offset 1", v, 32'h0000_00FF);
    bus_read(4'd7, 3'd1, v);
    chk("R3 byte offset 7", v, 32'h0000_00FF);
  endtask

  task automatic t_flags;
    logic [31:0] v;
    bus_write(4'd0, 3'd1, 32'h0000_00FF);
    chk("R4 rom_lock set", {31'b0, rom_lock}, 32'h1);
    bus_read(4'd0, 3'd1, v);
    chk("R4 flags keep bit 0 only", v, 32'h0000_0001);
    bus_write(4'd0, 3'd1, 32'h0000_00FE);
    chk("R4 rom_lock cleared", {31'b0, rom_lock}, 32'h0);
    bus_write(4'd0, 3'd1, 32'h0000_0001);
    chk("R4 rom_lock set again", {31'b0, rom_lock}, 32'h1);
  endtask

  task automatic t_unplug;
    bus_write(4'd0, 3'd2, 32'h0000_0001);
    chk("R6 disk pulse", {29'b0, unplug_req}, 32'h1);
    @(negedge clk);
    chk("R6 disk pulse one cycle", {29'b0, unplug_req}, 32'h0);
    bus_write(4'd0, 3'd2, 32'h0000_0002);
    chk("R6 nic pulse", {29'b0, unplug_req}, 32'h2);
    chk("R7 unsup not yet", {31'b0, unsup_seen}, 32'h0);
    @(negedge clk);
    bus_write(4'd0, 3'd2, 32'h0000_0000);
    chk("R6 empty mask", {29'b0, unplug_req}, 32'h0);
    bus_write(4'd0, 3'd2, 32'h0000_FFFF);
    chk("R6 all classes", {29'b0, unplug_req}, 32'h7);
    chk("R7 unsup set", {31'b0, unsup_seen}, 32'h1);
    @(negedge clk);
    chk("R6 pulses end", {29'b0, unplug_req}, 32'h0);
    chk("R7 unsup sticky", {31'b0, unsup_seen}, 32'h1);
  endtask

  task automatic t_version;
    bus_write(4'd2, 3'd2, 32'hABCD_1234);
    chk("R8 version latched", {16'b0, drv_version}, 32'h0000_1234);
    bus_write(4'd2, 3'd2, 32'h0000_BEEF);
    chk("R8 version rewritten", {16'b0, drv_version}, 32'h0000_BEEF);
  endtask

  task automatic t_log;
    chk("R9 log idle", {31'b0, log_valid}, 32'h0);
    bus_write(4'd2, 3'd1, 32'h0000_0141);
    chk("R9 log valid", {31'b0, log_valid}, 32'h1);
    chk("R9 log data", {24'b0, log_data}, 32'h41);
    bus_write(4'd2, 3'd1, 32'h0000_0042);
    chk("R9 stalled byte held", {24'b0, log_data}, 32'h41);
    log_ready = 1'b1;
    @(negedge clk);
    chk("R9 slot drained", {31'b0, log_valid}, 32'h0);
    bus_write(4'd2, 3'd1, 32'h0000_0043);
    chk("R9 next byte", {24'b0, log_data}, 32'h43);
    @(negedge clk);
    chk("R9 next byte drained", {31'b0, log_valid}, 32'h0);
    log_ready = 1'b0;
  endtask

  task automatic t_word;
    logic [31:0] v;
    bus_write(4'd0, 3'd4, 32'h0000_0000);
    bus_write(4'd2, 3'd4, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R10 word write no flags", {31'b0, rom_lock}, 32'h1);
    chk("R10 word write no version", {16'b0, drv_version}, 32'h0000_BEEF);
    chk("R10 word write no log", {31'b0, log_valid}, 32'h0);
    bus_read(4'd0, 3'd4, v);
    chk("R10 word read", v, 32'hFFFF_FFFF);
    bus_read(4'd0, 3'd3, v);
    chk("R10 odd size read", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_other_offsets;
    logic [31:0] v;
    bus_write(4'd4, 3'd2, 32'h0000_0007);
    chk("R11 no pulse from offset 4", {29'b0, unplug_req}, 32'h0);
    bus_write(4'd1, 3'd1, 32'h0000_0000);
    bus_write(4'd6, 3'd2, 32'h0000_5555);
    bus_write(4'd3, 3'd1, 32'h0000_0044);
    chk("R11 rom_lock untouched", {31'b0, rom_lock}, 32'h1);
    chk("R11 version untouched", {16'b0, drv_version}, 32'h0000_BEEF);
    chk("R11 log untouched", {31'b0, log_valid}, 32'h0);
    bus_read(4'd0, 3'd1, v);
    chk("R11 flags untouched", v, 32'h0000_0001);
  endtask

  task automatic t_rereset;
    logic [31:0] v;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 rom_lock cleared by reset", {31'b0, rom_lock}, 32'h0);
    chk("R7 unsup cleared by reset", {31'b0, unsup_seen}, 32'h0);
    bus_read(4'd0, 3'd1, v);
    chk("R5 flags cleared by reset", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signature();
    t_byte_reads();
    t_flags();
    t_unplug();
    t_version();
    t_log();
    t_word();
    t_other_offsets();
    t_rereset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule